// File: doc/BRIEF.md
# Instruction Length and Legality Pre-Decoder

This block sits between instruction fetch and full decode in a 32-bit core. It takes one fetch word, with bytes assembled little-endian so that the lowest-addressed parcel occupies bits [15:0]. From the low bits of that first 16-bit parcel it works out how long the instruction is. It also rejects encodings that can be refused without a full decode.

Three kinds of encoding are rejected. The first is a first parcel made only of zeros or only of ones, which is how blank or erased memory reads. The second is a length pattern that is not assigned. The third applies only when the reduced register-file mode is selected, in which only registers 0 to 15 exist: a 32-bit instruction that names register 16 or higher in a register field its format really uses is rejected.

The results are registered and appear one cycle after the input strobe. They are held until the next strobe.

Top module: `insn_predecode`

## Requirements
- R1: When bits [1:0] of the word are not 2'b11, out_len reports a 16-bit instruction with code 0.
- R2: When bits [1:0] are 2'b11 and bits [4:2] are not 3'b111, out_len reports a 32-bit instruction with code 1.
- R3: The remaining patterns are decoded as follows. Bits [5:0] equal to 6'b011111 give code 2 (48 bits). Bits [6:0] equal to 7'b0111111 give code 3 (64 bits). Bits [6:0] equal to 7'b1111111 give code 4 (reserved), and the word is then flagged illegal.
- R4: A first parcel (bits [15:0]) that is all zeros or all ones sets out_illegal, whatever the mode.
- R5: With small_regs low, no register field is examined. A word that has a defined length and a non-degenerate first parcel is never flagged illegal.
- R6: With small_regs high, a 32-bit instruction is flagged illegal when a field that it uses holds a value of 16 or more. The fields are rd at [11:7], rs1 at [19:15] and rs2 at [24:20], and the format is selected by major opcode bits [6:2]:
  - 01101, 00101 and 11011 use rd only.
  - 01000 and 11000 use rs1 and rs2.
  - 00000, 00100, 11001, 00011 and 00110 use rd and rs1.
  - Every other major opcode uses all three fields.
- R7: For major opcode 11100 in small_regs mode, rs1 is checked only when bit 14 is 0. When bit 14 is 1, bits [19:15] carry a constant and are not checked. rd is always checked.
- R8: The register range check never applies to 16-, 48- or 64-bit lengths.
- R9: out_valid equals in_valid one cycle later. out_len and out_illegal load only on cycles with in_valid high and otherwise hold their value.
- R10: While rst_n is low, out_valid, out_len and out_illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word strobe |
| in_word | input | 32 | Fetch word, little-endian, first parcel in [15:0] |
| small_regs | input | 1 | High selects the 16-register mode |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| out_len | output | 3 | Length code: 0=16, 1=32, 2=48, 3=64, 4=reserved |
| out_illegal | output | 1 | Illegal-encoding flag for the registered word |

## Verification
The assertions take for granted that in_valid, in_word and small_regs are stable around each rising clock edge. They also assume that in_valid is low throughout reset, so the first sample after reset release refers to an idle input.

The bench drives all inputs on the falling edge and holds in_valid low while reset is applied. The random stimulus is steered toward each length pattern, toward known major opcodes, and toward degenerate parcels, and it mixes idle cycles in among the strobes.

// File: rtl/insn_predecode_pkg.sv
package insn_predecode_pkg;

  typedef enum logic [2:0] {
    LEN_16   = 3'd0,
    LEN_32   = 3'd1,
    LEN_48   = 3'd2,
    LEN_64   = 3'd3,
    LEN_RSVD = 3'd4
  } ilen_e;

  // Register-field use mask: bit 0 = rd, bit 1 = rs1, bit 2 = rs2
  localparam int NUM_FIELDS = 3;
  typedef logic [NUM_FIELDS-1:0] reg_use_t;

  localparam int USE_RD  = 0;
  localparam int USE_RS1 = 1;
  localparam int USE_RS2 = 2;

  // Field positions shared by every 32-bit format
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;
  localparam int SYS_IMM_BIT = 14;

endpackage

// File: rtl/insn_len_decode.sv
module insn_len_decode
  import insn_predecode_pkg::*;
#(
  parameter int PARCEL_W = 16
) (
  input  logic [PARCEL_W-1:0] parcel,
  output ilen_e               len,
  output logic                degenerate
);

  // Length follows a priority chain over the lowest bits of the parcel
  always_comb begin
    if (parcel[1:0] != 2'b11) begin
      len = LEN_16;
    end else if (parcel[4:2] != 3'b111) begin
      len = LEN_32;
    end else if (!parcel[5]) begin
      len = LEN_48;
    end else if (!parcel[6]) begin
      len = LEN_64;
    end else begin
      len = LEN_RSVD;
    end
  end

  // Blank or erased memory reads as a uniform parcel
  assign degenerate = (parcel == '0) || (parcel == '1);

endmodule

// File: rtl/insn_reg_usage.sv
module insn_reg_usage
  import insn_predecode_pkg::*;
(
  input  logic [4:0] major,
  input  logic       sys_imm,
  output reg_use_t   use_mask
);

  always_comb begin
    use_mask = '0;
    unique case (major)
      5'b01101, 5'b00101, 5'b11011: begin
        use_mask[USE_RD] = 1'b1;
      end
      5'b01000, 5'b11000: begin
        use_mask[USE_RS1] = 1'b1;
        use_mask[USE_RS2] = 1'b1;
      end
      5'b00000, 5'b00100, 5'b11001, 5'b00011, 5'b00110: begin
        use_mask[USE_RD]  = 1'b1;
        use_mask[USE_RS1] = 1'b1;
      end
      5'b11100: begin
        use_mask[USE_RD]  = 1'b1;
        use_mask[USE_RS1] = !sys_imm;
      end
      default: begin
        use_mask = '1;
      end
    endcase
  end

endmodule

// File: rtl/insn_reg_range.sv
module insn_reg_range
  import insn_predecode_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int NUM_SMALL = 16
) (
  input  logic                            chk_en,
  input  reg_use_t                        use_mask,
  input  logic [NUM_FIELDS-1:0][IDX_W-1:0] idx,
  output logic                            viol
);

  localparam int CMP_W = IDX_W + 1;
  localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NUM_SMALL);

  logic [NUM_FIELDS-1:0] hit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign hit[f] = use_mask[f] && ({1'b0, idx[f]} >= LIMIT);
  end

  assign viol = chk_en && (|hit);

endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import insn_predecode_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PARCEL_W  = 16,
  parameter int IDX_W     = 5,
  parameter int NUM_SMALL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              small_regs,
  output logic              out_valid,
  output logic [2:0]        out_len,
  output logic              out_illegal
);

  localparam int HI_LSB = RS2_LSB + IDX_W;

  ilen_e    len_c;
  logic     degen_c;
  reg_use_t use_c;
  logic     viol_c;
  logic     chk_en_c;
  logic [NUM_FIELDS-1:0][IDX_W-1:0] idx_c;

  ilen_e    len_d, len_q;
  logic     ill_d, ill_q;
  logic     vld_d, vld_q;

  logic     unused_hi;
  assign unused_hi = ^in_word[WORD_W-1:HI_LSB];

  insn_len_decode #(.PARCEL_W(PARCEL_W)) u_len (
    .parcel     (in_word[PARCEL_W-1:0]),
    .len        (len_c),
    .degenerate (degen_c)
  );

  insn_reg_usage u_use (
    .major    (in_word[6:2]),
    .sys_imm  (in_word[SYS_IMM_BIT]),
    .use_mask (use_c)
  );

  assign idx_c[USE_RD]  = in_word[RD_LSB  +: IDX_W];
  assign idx_c[USE_RS1] = in_word[RS1_LSB +: IDX_W];
  assign idx_c[USE_RS2] = in_word[RS2_LSB +: IDX_W];
  assign chk_en_c       = small_regs && (len_c == LEN_32);

  insn_reg_range #(.IDX_W(IDX_W), .NUM_SMALL(NUM_SMALL)) u_range (
    .chk_en   (chk_en_c),
    .use_mask (use_c),
    .idx      (idx_c),
    .viol     (viol_c)
  );

  // Next-state logic
  always_comb begin
    vld_d = in_valid;
    len_d = len_q;
    ill_d = ill_q;
    if (in_valid) begin
      len_d = len_c;
      ill_d = degen_c || (len_c == LEN_RSVD) || viol_c;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      len_q <= LEN_16;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      len_q <= len_d;
      ill_q <= ill_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_len     = len_q;
  assign out_illegal = ill_q;

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_len) && $stable(out_illegal)));

  p_zero_parcel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[PARCEL_W-1:0] == '0) |=> out_illegal);

  p_ones_parcel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[PARCEL_W-1:0] == '1) |=> out_illegal);

  p_rsvd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_RSVD) |-> out_illegal);

  p_full_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !small_regs && in_word[6:0] != 7'h7F &&
     in_word[PARCEL_W-1:0] != '0 && in_word[PARCEL_W-1:0] != '1) |=> !out_illegal);

  p_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[1:0] != 2'b11 && in_word[PARCEL_W-1:0] != '0) |=> !out_illegal);

endmodule

// File: tb/insn_predecode_test.sv
module insn_predecode_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        small_regs;
  logic        out_valid;
  logic [2:0]  out_len;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2:0] exp_l;
  logic       exp_i;

  insn_predecode uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .small_regs  (small_regs),
    .out_valid   (out_valid),
    .out_len     (out_len),
    .out_illegal (out_illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] ref_len(input logic [31:0] w);
    if (w[1:0] != 2'b11)      return 3'd0;
    else if (w[4:2] != 3'b111) return 3'd1;
    else if (w[5] == 1'b0)    return 3'd2;
    else if (w[6] == 1'b0)    return 3'd3;
    else                      return 3'd4;
  endfunction

  function automatic bit degenerate(input logic [31:0] w);
    return (w[15:0] == 16'h0000) || (w[15:0] == 16'hFFFF);
  endfunction

  function automatic logic ref_ill(input logic [31:0] w, input logic m);
    bit rd_u, rs1_u, rs2_u;
    if (degenerate(w)) return 1'b1;
    if (ref_len(w) == 3'd4) return 1'b1;
    if (ref_len(w) != 3'd1 || !m) return 1'b0;
    case (w[6:2])
      5'b01101, 5'b00101, 5'b11011: begin rd_u = 1; rs1_u = 0; rs2_u = 0; end
      5'b01000, 5'b11000:           begin rd_u = 0; rs1_u = 1; rs2_u = 1; end
      5'b00000, 5'b00100, 5'b11001, 5'b00011, 5'b00110:
                                    begin rd_u = 1; rs1_u = 1; rs2_u = 0; end
      5'b11100:                     begin rd_u = 1; rs1_u = !w[14]; rs2_u = 0; end
      default:                      begin rd_u = 1; rs1_u = 1; rs2_u = 1; end
    endcase
    return (rd_u && w[11]) || (rs1_u && w[19]) || (rs2_u && w[24]);
  endfunction

  function automatic string len_tag(input logic [31:0] w);
    case (ref_len(w))
      3'd0:    return "R1";
      3'd1:    return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic string ill_tag(input logic [31:0] w, input logic m);
    if (degenerate(w)) return "R4";
    if (ref_len(w) == 3'd4) return "R3";
    if (ref_len(w) != 3'd1) return "R8";
    if (!m) return "R5";
    if (w[6:2] == 5'b11100) return "R7";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Drive at a falling edge, then check one cycle later at the next falling edge
  task automatic step(input bit v, input logic [31:0] w, input bit m);
    string lt, it;
    in_valid   = v;
    in_word    = w;
    small_regs = m;
    if (v) begin
      exp_l = ref_len(w);
      exp_i = ref_ill(w, m);
      lt = len_tag(w);
      it = ill_tag(w, m);
    end else begin
      lt = "R9";
      it = "R9";
    end
    @(negedge clk);
    chk(out_valid == v, "R9", "out_valid", int'(out_valid), int'(v));
    chk(out_len == exp_l, lt, "out_len", int'(out_len), int'(exp_l));
    chk(out_illegal == exp_i, it, "out_illegal", int'(out_illegal), int'(exp_i));
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    int sel;
    w = $urandom;
    sel = $urandom_range(0, 7);
    if (sel >= 2 && sel <= 5) begin
      w[1:0] = 2'b11;
      case ($urandom_range(0, 13))
        0:  w[6:2] = 5'b01101;
        1:  w[6:2] = 5'b00101;
        2:  w[6:2] = 5'b11011;
        3:  w[6:2] = 5'b01000;
        4:  w[6:2] = 5'b11000;
        5:  w[6:2] = 5'b00000;
        6:  w[6:2] = 5'b00100;
        7:  w[6:2] = 5'b11001;
        8:  w[6:2] = 5'b00011;
        9:  w[6:2] = 5'b00110;
        10: w[6:2] = 5'b11100;
        11: w[6:2] = 5'b01100;
        12: w[6:2] = 5'b01011;
        default: w[6:2] = 5'b10100;
      endcase
    end else if (sel == 6) begin
      case ($urandom_range(0, 2))
        0:       w[6:0] = 7'h1F;
        1:       w[6:0] = 7'h3F;
        default: w[6:0] = 7'h7F;
      endcase
    end else if (sel == 7) begin
      w[15:0] = $urandom_range(0, 1) ? 16'hFFFF : 16'h0000;
    end
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_word    = 32'h0;
    small_regs = 1'b0;
    exp_l      = 3'd0;
    exp_i      = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "reset out_valid", int'(out_valid), 0);
    chk(out_len == 3'd0, "R10", "reset out_len", int'(out_len), 0);
    chk(out_illegal == 1'b0, "R10", "reset out_illegal", int'(out_illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    step(1, 32'h0000_0000, 0);   // R4 zero parcel
    step(1, 32'hFFFF_FFFF, 1);   // R3 reserved and R4 ones parcel
    step(1, 32'h0000_FFFF, 0);   // R4
    step(1, 32'h1234_0000, 1);   // R4 zero first parcel
    step(1, 32'h0000_0013, 0);   // R2 nop
    step(1, 32'h0000_0013, 1);   // R6 nop small mode
    step(1, 32'h0000_4501, 0);   // R1 short
    step(1, 32'h0000_0801, 1);   // R8 short with bit 11 set
    step(1, 32'h0000_001F, 0);   // R3 48-bit
    step(1, 32'h0000_081F, 1);   // R8 48-bit with bit 11 set
    step(1, 32'h0008_003F, 1);   // R3 64-bit, R8
    step(1, 32'h0000_007F, 0);   // R3 reserved
    step(1, 32'h0000_0837, 1);   // R6 upper-imm rd=16
    step(1, 32'h0008_0037, 1);   // R6 upper-imm, rs1 bits ignored
    step(1, 32'h0100_0023, 1);   // R6 store rs2=16
    step(1, 32'h0000_0823, 1);   // R6 store, rd bits ignored
    step(1, 32'h0100_0023, 0);   // R5 same store full mode
    step(1, 32'h0111_00B3, 1);   // R6 reg-reg rs2=17
    step(1, 32'h0100_0013, 1);   // R6 reg-imm, bit 24 ignored
    step(1, 32'h0008_5073, 1);   // R7 immediate CSR form
    step(1, 32'h0008_1073, 1);   // R7 register CSR form
    step(1, 32'h0000_0873, 1);   // R7 rd=16
    step(0, 32'h0000_0000, 0);   // R9 idle keeps outputs
    step(0, 32'h0000_4501, 1);   // R9 idle keeps outputs
    step(1, 32'h0000_4501, 1);   // R1

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, rand_word(), $urandom_range(0, 1) != 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule